// File: doc/BRIEF.md
# Two-Road Traffic Signal Sequencer

This block drives the lamps of a crossing where a main road meets a side road. Each road has one red, one yellow and one green lamp. A one-second enable pulse from elsewhere on the chip advances the block. It runs a fixed 100-second cycle:

- the main road is green for 45 s, then yellow for 5 s;
- the side road is then green for 45 s, then yellow for 5 s;
- a road shows red while the other road is green or yellow.

Each road shows a two-digit BCD count of the seconds left before its lamp next changes. A 7-bit output gives the seconds elapsed in the current cycle.

A side-road vehicle detector can keep the main road green. When main green would end and no vehicle is waiting, the block holds main green. During the hold, every count is frozen. The first second pulse that sees a waiting vehicle ends the hold.

Clock division, seven-segment decoding and display multiplexing are done outside the block.

Top module: `crossroad_signal_ctrl`

## Requirements
- R1: While reset is low, and after reset until the first second pulse, both roads show red (`lamps` = 6'b100_100). All four count digits read 0 and `cycle_sec` reads 0. The first pulse starts main green with the main count at 45, the side count at 50 and the cycle at 0.
- R2: `lamps` is {main red, main yellow, main green, side red, side yellow, side green}. Exactly one lamp per road is lit. The two roads are never green or yellow at the same time.
- R3: With a vehicle always waiting, the phases run in this order, counted in second pulses: main green 45, main yellow 5, side green 45, side yellow 5, then main green again. A road is red for the 50 pulses in which the other road is green or yellow.
- R4: When a phase starts, the road going green or yellow loads that phase's length (45 or 5). A road turning red loads 50.
- R5: Each count drops by one on every second pulse, as BCD. A units digit of 0 borrows from the tens digit (40 becomes 39). No digit ever exceeds 9.
- R6: A phase ends on the second pulse in which its road's count reads 01.
- R7: Without a second pulse, no output changes.
- R8: `cycle_sec` rises by one per second pulse. It runs from 0 at the start of main green to 99, and goes back to 0 on the pulse that ends side yellow.
- R9: If the main count reads 01 on a pulse while `side_car` is low, main stays green. In that case the main count (01), the side count (06) and `cycle_sec` (44) all stay frozen. The first pulse with `side_car` high starts main yellow with both counts at 05 and `cycle_sec` at 45.
- R10: `side_car` has no effect at any other time, including the other main-green pulses, main yellow and both side phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| side_car | input | 1 | High while a side-road vehicle is waiting |
| main_tens | output | 4 | Main-road count, tens digit (BCD) |
| main_units | output | 4 | Main-road count, units digit (BCD) |
| side_tens | output | 4 | Side-road count, tens digit (BCD) |
| side_units | output | 4 | Side-road count, units digit (BCD) |
| cycle_sec | output | 7 | Seconds elapsed in the current cycle |
| lamps | output | 6 | {main R,Y,G, side R,Y,G} |

## Verification
A corrupted phase state shows up on `lamps` on the next clock edge. It shows up at once as a road with two or no lamps lit, or as both roads showing a go colour. A wrong count or a failed BCD borrow shows at the next second pulse: a digit above 9, a step other than one, or a phase change at a count other than 01. A mistake in the hold logic shows within one pulse, as `cycle_sec` moving while the block holds, or the counts not reading 05/05/45 when yellow starts.

// File: rtl/crossroad_signal_ctrl.sv
module crossroad_signal_ctrl #(
  parameter int GREEN_S  = 45,
  parameter int YELLOW_S = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       side_car,
  output logic [3:0] main_tens,
  output logic [3:0] main_units,
  output logic [3:0] side_tens,
  output logic [3:0] side_units,
  output logic [6:0] cycle_sec,
  output logic [5:0] lamps
);
  localparam int RED_S = GREEN_S + YELLOW_S;
  localparam logic [7:0] G_BCD = {4'(GREEN_S / 10), 4'(GREEN_S % 10)};
  localparam logic [7:0] Y_BCD = {4'(YELLOW_S / 10), 4'(YELLOW_S % 10)};
  localparam logic [7:0] R_BCD = {4'(RED_S / 10), 4'(RED_S % 10)};

  typedef enum logic [2:0] {ALL_RED, M_GO, M_WAIT, M_AMBER, S_GO, S_AMBER} phase_t;

  phase_t     phase;
  logic [7:0] m_cnt, s_cnt;
  logic [6:0] cyc;

  function automatic logic [7:0] bcd_dec(input logic [7:0] v);
    return (v[3:0] == 4'd0) ? {v[7:4] - 4'd1, 4'd9} : {v[7:4], v[3:0] - 4'd1};
  endfunction

  wire m_one = (m_cnt == 8'h01);
  wire s_one = (s_cnt == 8'h01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= ALL_RED;
      m_cnt <= 8'h00;
      s_cnt <= 8'h00;
      cyc   <= 7'd0;
    end else if (sec_tick) begin
      case (phase)
        ALL_RED: begin
          phase <= M_GO;
          m_cnt <= G_BCD;
          s_cnt <= R_BCD;
          cyc   <= 7'd0;
        end
        M_GO: begin
          if (!m_one) begin
            m_cnt <= bcd_dec(m_cnt);
            s_cnt <= bcd_dec(s_cnt);
            cyc   <= cyc + 7'd1;
          end else if (side_car) begin
            phase <= M_AMBER;
            m_cnt <= Y_BCD;
            s_cnt <= bcd_dec(s_cnt);
            cyc   <= cyc + 7'd1;
          end else begin
            phase <= M_WAIT;
          end
        end
        M_WAIT: begin
          if (side_car) begin
            phase <= M_AMBER;
            m_cnt <= Y_BCD;
            s_cnt <= bcd_dec(s_cnt);
            cyc   <= cyc + 7'd1;
          end
        end
        M_AMBER: begin
          cyc <= cyc + 7'd1;
          if (m_one) begin
            phase <= S_GO;
            m_cnt <= R_BCD;
            s_cnt <= G_BCD;
          end else begin
            m_cnt <= bcd_dec(m_cnt);
            s_cnt <= bcd_dec(s_cnt);
          end
        end
        S_GO: begin
          cyc   <= cyc + 7'd1;
          m_cnt <= bcd_dec(m_cnt);
          if (s_one) begin
            phase <= S_AMBER;
            s_cnt <= Y_BCD;
          end else begin
            s_cnt <= bcd_dec(s_cnt);
          end
        end
        S_AMBER: begin
          if (s_one) begin
            phase <= M_GO;
            m_cnt <= G_BCD;
            s_cnt <= R_BCD;
            cyc   <= 7'd0;
          end else begin
            m_cnt <= bcd_dec(m_cnt);
            s_cnt <= bcd_dec(s_cnt);
            cyc   <= cyc + 7'd1;
          end
        end
        default: phase <= ALL_RED;
      endcase
    end
  end

  wire m_green  = (phase == M_GO) || (phase == M_WAIT);
  wire m_yellow = (phase == M_AMBER);
  wire s_green  = (phase == S_GO);
  wire s_yellow = (phase == S_AMBER);

  assign lamps      = {!(m_green || m_yellow), m_yellow, m_green,
                       !(s_green || s_yellow), s_yellow, s_green};
  assign main_tens  = m_cnt[7:4];
  assign main_units = m_cnt[3:0];
  assign side_tens  = s_cnt[7:4];
  assign side_units = s_cnt[3:0];
  assign cycle_sec  = cyc;

  AST_ONE_LAMP_EACH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lamps[5:3]) == 1 && $countones(lamps[2:0]) == 1); // R2
  AST_NO_SHARED_GO: assert property (@(posedge clk) disable iff (!rst_n)
    !((lamps[4] || lamps[3]) && (lamps[1] || lamps[0]))); // R2
  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    main_units <= 4'd9 && side_units <= 4'd9 && main_tens <= 4'd9 && side_tens <= 4'd9); // R5
  AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(lamps) && $stable(cycle_sec) && $stable(m_cnt) && $stable(s_cnt)); // R7
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && (phase == M_AMBER || phase == S_GO) |=> cycle_sec == $past(cycle_sec) + 7'd1); // R8
  AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && phase == S_AMBER && s_one |=> cycle_sec == 7'd0 && lamps[3]); // R8
  AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    phase == M_WAIT && !side_car |=> $stable(cycle_sec) && $stable(m_cnt) && $stable(s_cnt) && lamps[3]); // R9
  AST_PHASE_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && phase == S_GO && !s_one |=> lamps[0]); // R6
endmodule

// File: tb/test_crossroad_signal_ctrl.sv
module test_crossroad_signal_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       side_car = 1'b1;
  logic [3:0] main_tens, main_units, side_tens, side_units;
  logic [6:0] cycle_sec;
  logic [5:0] lamps;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crossroad_signal_ctrl i_crossroad_signal_ctrl (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .side_car(side_car),
    .main_tens(main_tens), .main_units(main_units),
    .side_tens(side_tens), .side_units(side_units),
    .cycle_sec(cycle_sec), .lamps(lamps)
  );

  localparam logic [5:0] L_MG = 6'b001100, L_MY = 6'b010100;
  localparam logic [5:0] L_SG = 6'b100001, L_SY = 6'b100010, L_RR = 6'b100100;

  // {pulses to apply, main BCD, side BCD, cycle, lamps}
  localparam logic [36:0] VEC [10] = '{
    {8'd1,  8'h45, 8'h50, 7'd0,  L_MG},  // R1 R4 first pulse
    {8'd5,  8'h40, 8'h45, 7'd5,  L_MG},  // R5
    {8'd1,  8'h39, 8'h44, 7'd6,  L_MG},  // R5 borrow
    {8'd38, 8'h01, 8'h06, 7'd44, L_MG},  // R3 last main green second
    {8'd1,  8'h05, 8'h05, 7'd45, L_MY},  // R4 R6
    {8'd4,  8'h01, 8'h01, 7'd49, L_MY},  // R3
    {8'd1,  8'h50, 8'h45, 7'd50, L_SG},  // R3 R4
    {8'd45, 8'h05, 8'h05, 7'd95, L_SY},  // R3 R6
    {8'd4,  8'h01, 8'h01, 7'd99, L_SY},  // R8
    {8'd1,  8'h45, 8'h50, 7'd0,  L_MG}   // R8 wrap
  };

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic [7:0] m, input logic [7:0] s,
                       input logic [6:0] c, input logic [5:0] l);
    logic [28:0] act, exp;
    act = {main_tens, main_units, side_tens, side_units, cycle_sec, lamps};
    exp = {m, s, c, l};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R1 reset state", 8'h00, 8'h00, 7'd0, L_RR);
    repeat (5) @(negedge clk);
    check("R7 no pulse", 8'h00, 8'h00, 7'd0, L_RR);
    for (int i = 0; i < 10; i++) begin
      pulse(int'(VEC[i][36:29]));
      check("R3 R4 R5 R6 R8 cycle walk", VEC[i][28:21], VEC[i][20:13], VEC[i][12:6], VEC[i][5:0]);
    end
    repeat (7) @(negedge clk);
    check("R7 idle after walk", 8'h45, 8'h50, 7'd0, L_MG);

    do_reset();
    side_car = 1'b0;
    pulse(45);
    check("R10 car low mid green", 8'h01, 8'h06, 7'd44, L_MG);
    pulse(1);
    check("R9 enter hold", 8'h01, 8'h06, 7'd44, L_MG);
    pulse(3);
    check("R9 hold frozen", 8'h01, 8'h06, 7'd44, L_MG);
    side_car = 1'b1;
    pulse(1);
    check("R9 leave hold", 8'h05, 8'h05, 7'd45, L_MY);
    side_car = 1'b0;
    pulse(5);
    check("R10 car low in yellow", 8'h50, 8'h45, 7'd50, L_SG);
    pulse(45);
    check("R10 car low in side green", 8'h05, 8'h05, 7'd95, L_SY);
    pulse(5);
    check("R2 R8 back to main green", 8'h45, 8'h50, 7'd0, L_MG);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule